// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This combinational unit examines one selected bit of an operand, reports whether that bit was clear through the zero flag, and can then invert, force or clear the bit. It sits behind an execute stage. The stage supplies an already fetched operand, a bit number, a flag that marks whether the operand came from memory as a byte or from a 32-bit register, and an operation code. The unit returns the operand to write back and the updated condition flags. It also returns a write enable that stays low when the operation only reads the bit.

For a register operand, the bit number wraps modulo 32. For a byte from memory, it wraps modulo 8, and bits above the low byte pass through untouched. The zero flag always reflects the bit's value before modification. The other four condition flags are forwarded unchanged.

Top module: `bit_test_unit`

## Requirements
- R1: `zeroFlag` and `flagsOut[2]` are the inverse of the selected bit of `operandIn`, taken before any modification, for every operation code.
- R2: Operation code 2'b00 (test) leaves `operandOut` equal to `operandIn` and holds `writeEn` low.
- R3: Operation code 2'b01 (change) inverts the selected bit and leaves every other bit unchanged.
- R4: Operation code 2'b10 (set) forces the selected bit to 1 and leaves every other bit unchanged.
- R5: Operation code 2'b11 (clear) forces the selected bit to 0 and leaves every other bit unchanged.
- R6: With `isByte` low, the selected bit is `bitNum` modulo 32 (so 36 selects bit 4).
- R7: With `isByte` high, the selected bit is `bitNum` modulo 8 (so 13 selects bit 5), and `operandOut[31:8]` equals `operandIn[31:8]`.
- R8: Flags are ordered {X,N,Z,V,C} in bits 4..0; `flagsOut` bits 4, 3, 1 and 0 equal the same bits of `flagsIn`.
- R9: `writeEn` is high for the change, set and clear operation codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operandIn | input | 32 | Operand to test |
| bitNum | input | 6 | Requested bit number, wrapped to the operand size |
| isByte | input | 1 | High for a memory byte operand, low for a register |
| opSel | input | 2 | 00 test, 01 change, 10 set, 11 clear |
| flagsIn | input | 5 | Incoming {X,N,Z,V,C} |
| operandOut | output | 32 | Operand after modification |
| flagsOut | output | 5 | Outgoing {X,N,Z,V,C} with Z updated |
| zeroFlag | output | 1 | New Z value |
| writeEn | output | 1 | High when the operand must be written back |

## Verification
Every result of this unit is combinational, so each is due in the same cycle the stimulus is applied. No register lies on any path. The driver applies inputs one time unit after a rising edge and queues the expected operand, flags and write enable. The monitor pops the item on the following falling edge, half a period later, when the inputs have long settled and the next stimulus has not yet been applied.

// File: rtl/bit_test_pkg.sv
package bit_test_pkg;
  typedef enum logic [1:0] {
    OP_TEST   = 2'b00,
    OP_CHANGE = 2'b01,
    OP_SET    = 2'b10,
    OP_CLEAR  = 2'b11
  } bitOp_e;

  typedef struct packed {
    logic writeEn;
    logic flip;
    logic forceOne;
    logic forceZero;
  } bitStrobe_t;

  localparam int unsigned FLAG_W   = 5;
  localparam int unsigned Z_FLAG_POS = 2;
endpackage

// File: rtl/bit_test_ctrl.sv
module bit_test_ctrl
  import bit_test_pkg::*;
(
  input  logic [1:0] opSel,
  output bitStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    unique case (bitOp_e'(opSel))
      OP_TEST:   strobe = '0;
      OP_CHANGE: begin strobe.writeEn = 1'b1; strobe.flip      = 1'b1; end
      OP_SET:    begin strobe.writeEn = 1'b1; strobe.forceOne  = 1'b1; end
      OP_CLEAR:  begin strobe.writeEn = 1'b1; strobe.forceZero = 1'b1; end
      default:   strobe = '0;
    endcase
  end
endmodule

// File: rtl/bit_test_dp.sv
module bit_test_dp
  import bit_test_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [DATA_W-1:0] operandIn,
  input  logic [IDX_W-1:0]  bitNum,
  input  logic              isByte,
  input  bitStrobe_t        strobe,
  output logic [DATA_W-1:0] operandOut,
  output logic              oldBit
);
  localparam int unsigned SEL_W = $clog2(DATA_W);

  logic [SEL_W-1:0] regIdx;
  logic [SEL_W-1:0] byteIdx;
  logic [SEL_W-1:0] effIdx;

  always_comb begin
    regIdx  = SEL_W'(bitNum % IDX_W'(DATA_W));
    byteIdx = SEL_W'(bitNum % IDX_W'(BYTE_W));
    effIdx  = isByte ? byteIdx : regIdx;
    oldBit  = operandIn[effIdx];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    logic hit;
    always_comb begin
      hit = (effIdx == SEL_W'(i));
      if (!hit)
        operandOut[i] = operandIn[i];
      else if (strobe.flip)
        operandOut[i] = ~operandIn[i];
      else if (strobe.forceOne)
        operandOut[i] = 1'b1;
      else if (strobe.forceZero)
        operandOut[i] = 1'b0;
      else
        operandOut[i] = operandIn[i];
    end
  end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bit_test_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [DATA_W-1:0] operandIn,
  input  logic [IDX_W-1:0]  bitNum,
  input  logic              isByte,
  input  logic [1:0]        opSel,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] operandOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              zeroFlag,
  output logic              writeEn
);
  localparam logic [FLAG_W-1:0] Z_MASK = FLAG_W'(1) << Z_FLAG_POS;

  bitStrobe_t strobe;
  logic       oldBit;

  bit_test_ctrl uCtrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  bit_test_dp #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W)
  ) uDp (
    .operandIn  (operandIn),
    .bitNum     (bitNum),
    .isByte     (isByte),
    .strobe     (strobe),
    .operandOut (operandOut),
    .oldBit     (oldBit)
  );

  always_comb begin
    zeroFlag = ~oldBit;
    flagsOut = (flagsIn & ~Z_MASK) | (zeroFlag ? Z_MASK : '0);
    writeEn  = strobe.writeEn;
  end
endmodule

// File: rtl/bit_test_unit_chk.sv
module bit_test_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 6
) (
  input logic [DATA_W-1:0] operandIn,
  input logic [IDX_W-1:0]  bitNum,
  input logic              isByte,
  input logic [1:0]        opSel,
  input logic [4:0]        flagsIn,
  input logic [DATA_W-1:0] operandOut,
  input logic [4:0]        flagsOut,
  input logic              zeroFlag,
  input logic              writeEn
);
  logic [DATA_W-1:0] diff;
  logic              unusedIdx;

  always_comb begin
    diff      = operandIn ^ operandOut;
    unusedIdx = ^bitNum;
    AST_SINGLE_BIT_DIFF: assert ($onehot0(diff));                                   // R3
    AST_TEST_NO_WRITE:   assert (opSel != 2'b00 || (!writeEn && diff == '0));       // R2
    AST_SET_NO_CLEAR:    assert (opSel != 2'b10 || (operandIn & ~operandOut) == '0); // R4
    AST_CLR_NO_SET:      assert (opSel != 2'b11 || (operandOut & ~operandIn) == '0); // R5
    AST_BYTE_UPPER_KEPT: assert (!isByte || diff[DATA_W-1:BYTE_W] == '0);           // R7
    AST_FLAGS_FORWARD:   assert ({flagsOut[4:3], flagsOut[1:0]} == {flagsIn[4:3], flagsIn[1:0]}); // R8
    AST_Z_COPY:          assert (flagsOut[2] == zeroFlag);                          // R1
    AST_WRITE_ON_MODIFY: assert (opSel == 2'b00 || writeEn);                        // R9
  end
endmodule

bind bit_test_unit bit_test_unit_chk #(
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W),
  .IDX_W  (IDX_W)
) uChk (
  .operandIn  (operandIn),
  .bitNum     (bitNum),
  .isByte     (isByte),
  .opSel      (opSel),
  .flagsIn    (flagsIn),
  .operandOut (operandOut),
  .flagsOut   (flagsOut),
  .zeroFlag   (zeroFlag),
  .writeEn    (writeEn)
);

// File: tb/bit_test_unit_test.sv
module bit_test_unit_test;
  typedef struct {
    logic [1:0]  op;
    logic [31:0] data;
    logic [4:0]  flags;
    logic        z;
    logic        we;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operandIn = '0;
  logic [5:0]  bitNum = '0;
  logic        isByte = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [4:0]  flagsIn = '0;
  logic [31:0] operandOut;
  logic [4:0]  flagsOut;
  logic        zeroFlag;
  logic        writeEn;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  expItem_t q[$];

  always #5 clk = ~clk;

  bit_test_unit uut (
    .operandIn  (operandIn),
    .bitNum     (bitNum),
    .isByte     (isByte),
    .opSel      (opSel),
    .flagsIn    (flagsIn),
    .operandOut (operandOut),
    .flagsOut   (flagsOut),
    .zeroFlag   (zeroFlag),
    .writeEn    (writeEn)
  );

  function automatic string opReq(logic [1:0] op);
    case (op)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] op, logic [31:0] d, logic [5:0] n,
                       logic byteMode, logic [4:0] f, string tag);
    expItem_t it;
    int idx;
    logic prev;
    logic [31:0] res;
    @(posedge clk); #1;
    idx  = byteMode ? int'(n % 8) : int'(n % 32);
    prev = d[idx];
    res  = d;
    case (op)
      2'b01: res[idx] = ~prev;
      2'b10: res[idx] = 1'b1;
      2'b11: res[idx] = 1'b0;
      default: ;
    endcase
    it.op    = op;
    it.data  = res;
    it.z     = ~prev;
    it.flags = {f[4:3], ~prev, f[1:0]};
    it.we    = (op != 2'b00);
    it.tag   = tag;
    operandIn = d; bitNum = n; isByte = byteMode; opSel = op; flagsIn = f;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      check({opReq(e.op), " data ", e.tag}, operandOut, e.data);
      check({"R1 z ", e.tag}, 32'(zeroFlag), 32'(e.z));
      check({(e.op == 2'b00) ? "R2" : "R9", " we ", e.tag}, 32'(writeEn), 32'(e.we));
      check({"R8 flags ", e.tag}, 32'(flagsOut), 32'(e.flags));
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state: all-zero inputs, test op -> Z set, no write (R2, R1)
    check("R2 reset data", operandOut, 32'h0);
    check("R2 reset we", 32'(writeEn), 32'h0);
    check("R1 reset z", 32'(zeroFlag), 32'h1);
    rst = 1'b0;
    drive(2'b11, 32'h0000FFFF, 6'd2, 1'b0, 5'b10101, "clear b2");      // R5
    drive(2'b10, 32'h00000000, 6'd6, 1'b0, 5'b01010, "set b6");        // R4
    drive(2'b01, 32'h00001075, 6'd4, 1'b0, 5'b11011, "chg b4");        // R3
    drive(2'b00, 32'h00001075, 6'd7, 1'b0, 5'b00100, "test b7");       // R2
    drive(2'b10, 32'h00000000, 6'd36, 1'b0, 5'b11111, "R6 wrap 36");   // R6
    drive(2'b11, 32'h80000000, 6'd63, 1'b0, 5'b00000, "R6 wrap 63");   // R6
    drive(2'b10, 32'hFFFF0000, 6'd13, 1'b1, 5'b10001, "R7 byte 13");   // R7
    drive(2'b01, 32'h12345678, 6'd15, 1'b1, 5'b01110, "R7 byte 15");   // R7
    drive(2'b11, 32'hFFFFFFFF, 6'd31, 1'b1, 5'b11111, "R7 byte 31");   // R7
    drive(2'b00, 32'hA5A5A5A5, 6'd40, 1'b1, 5'b00011, "R7 test byte"); // R7
    for (int k = 0; k < 64; k++)
      drive(2'(k), 32'hC3A5_0F96 ^ (32'(k) * 32'h0101_0101), 6'(k), k[2], 5'(k * 7), "sweep");
    @(posedge clk); #1;
    @(posedge clk); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule